// File: doc/BRIEF.md
# Configurable UART Framing Engine

This block turns parallel bytes into asynchronous serial frames on a transmit line and recovers bytes from frames on a receive line. A single integer divisor sets the oversample tick. Each serial bit lasts either 16 or 8 ticks, chosen by a mode input. Word length (5 to 8 bits), parity (none, even, odd or stick), and one or two stop bits are set by static configuration inputs. These inputs must only change while both directions are idle.

The transmitter takes a byte through a valid/ready handshake. It can also hold its line low for as long as a break request is asserted. The receiver synchronises the line and samples every bit at its middle tick. It presents each byte with a valid flag that is held until accepted. Alongside the byte it reports parity, framing, break and overrun conditions.

Top module: `uart_frame_engine`

## Requirements
- R1: A serial bit lasts OS*(baudDiv+1) clock cycles, with OS=16 when fastMode=0 and OS=8 when fastMode=1. Only the first (start) bit of a transmitted frame may be up to baudDiv cycles shorter.
- R2: A transmitted frame is one low start bit, then N=wordLen+5 data bits least significant first (wordLen 0,1,2,3 gives 5,6,7,8 bits; txData bits above N are ignored), then the parity bit when parityEn=1, then one high stop bit (twoStop=0) or two (twoStop=1). The idle line is high.
- R3: With parityStick=0 the parity bit equals the XOR of the N data bits XOR parityOdd, so even parity (parityOdd=0) makes the count of ones even. With parityStick=1 the parity bit equals parityOdd.
- R4: txReady is high only while the transmitter is idle and sendBreak is low. A byte is taken on a cycle where txValid and txReady are both high, and txReady is low on the following cycle.
- R5: From the cycle after sendBreak goes high, txOut is low for as long as sendBreak stays high, and no byte is accepted.
- R6: The receiver checks the start bit at its middle tick. A low pulse shorter than half a bit produces no received byte.
- R7: The received byte appears on rxData right-aligned, with bits above N zero. rxValid stays high until a cycle with rxReady high.
- R8: rxParityErr is set when the received parity bit differs from the value R3 gives for the received data.
- R9: rxFrameErr is set when the first stop bit is sampled low.
- R10: When every sample of a frame (start, data, parity and stop bits) is low, the byte is reported with rxBreak=1, rxFrameErr=1, rxParityErr=0 and rxData=0. After a frame whose last stop sample is low, the receiver looks for the next start bit only after the line has gone high.
- R11: If a frame completes while rxValid is high and rxReady is low, the new byte replaces the old one and rxOverrun is set with it. Otherwise rxOverrun is cleared.
- R12: During and after reset, txOut is high, rxValid is low and txReady is high while sendBreak is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| baudDiv | input | DIV_W | Oversample tick period minus one, in clocks |
| fastMode | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| wordLen | input | 2 | Data bits minus five |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | Odd parity; in stick mode the parity bit value |
| parityStick | input | 1 | Constant parity bit |
| twoStop | input | 1 | Two stop bits |
| sendBreak | input | 1 | Hold transmit line low |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | txData is valid |
| txReady | output | 1 | Transmitter can take a byte |
| txOut | output | 1 | Serial transmit line |
| rxIn | input | 1 | Serial receive line |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | rxData and flags valid |
| rxReady | input | 1 | Consumer accepts the byte |
| rxFrameErr | output | 1 | First stop bit was low |
| rxParityErr | output | 1 | Parity mismatch |
| rxBreak | output | 1 | Whole frame was low |
| rxOverrun | output | 1 | Previous byte was lost |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor field and 16/8 oversampling. It drives baudDiv=3, so each tick is four clocks and one bit lasts 64 or 32 clocks. At that size, mid-bit sampling, the start-bit shortening of R1, and every word length, parity and stop combination fit into short frames. The random traffic therefore covers both oversampling modes in a few thousand cycles per pass, while the break and overrun cases still span several whole frames.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;

  // what the transmit line carries during the current bit
  typedef enum logic [1:0] {
    SEL_IDLE,
    SEL_START,
    SEL_DATA,
    SEL_PAR
  } txSel_e;

  typedef struct packed {
    logic   load;
    logic   shift;
    txSel_e sel;
  } txStrb_t;

  typedef struct packed {
    logic clear;
    logic takeData;
    logic takePar;
    logic takeStop1;
    logic capture;
  } rxStrb_t;

endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] baudDiv,
  output logic             osTick
);

  logic [DIV_W-1:0] cnt;

  assign osTick = (cnt >= baudDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       cnt <= '0;
    else if (osTick) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/uart_frame_ctrl.sv
module uart_frame_ctrl
  import uart_frame_pkg::*;
#(
  parameter int OS_NORMAL = 16,
  parameter int OS_FAST   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       osTick,
  input  logic       fastMode,
  input  logic [1:0] wordLen,
  input  logic       parityEn,
  input  logic       twoStop,
  input  logic       sendBreak,
  input  logic       txValid,
  output logic       txReady,
  output txStrb_t    txStrb,
  input  logic       rxLine,
  output rxStrb_t    rxStrb
);

  localparam int OS_W = $clog2(OS_NORMAL);

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP1, TX_STOP2
  } txState_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP1, RX_STOP2, RX_HOLD
  } rxState_e;

  logic [OS_W-1:0] osLast, osHalf;
  logic [2:0]      lastBit;

  assign osLast  = fastMode ? OS_W'(OS_FAST - 1)     : OS_W'(OS_NORMAL - 1);
  assign osHalf  = fastMode ? OS_W'(OS_FAST / 2 - 1) : OS_W'(OS_NORMAL / 2 - 1);
  assign lastBit = 3'd4 + {1'b0, wordLen};

  // ---------------- transmit sequencing ----------------
  txState_e        txState, txNext;
  logic [OS_W-1:0] txOs;
  logic [2:0]      txBit;
  logic            txBitEnd, txLoad;

  assign txReady  = (txState == TX_IDLE) && !sendBreak;
  assign txLoad   = txValid && txReady;
  assign txBitEnd = osTick && (txOs == osLast) && (txState != TX_IDLE);

  always_comb begin
    txNext = txState;
    unique case (txState)
      TX_IDLE:  if (txLoad) txNext = TX_START;
      TX_START: if (txBitEnd) txNext = TX_DATA;
      TX_DATA:  if (txBitEnd && txBit == lastBit) txNext = parityEn ? TX_PAR : TX_STOP1;
      TX_PAR:   if (txBitEnd) txNext = TX_STOP1;
      TX_STOP1: if (txBitEnd) txNext = twoStop ? TX_STOP2 : TX_IDLE;
      TX_STOP2: if (txBitEnd) txNext = TX_IDLE;
      default:  txNext = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txOs    <= '0;
      txBit   <= '0;
    end else begin
      txState <= txNext;
      if (txLoad)
        txOs <= '0;
      else if (osTick && txState != TX_IDLE)
        txOs <= (txOs == osLast) ? '0 : txOs + 1'b1;
      if (txLoad)
        txBit <= '0;
      else if (txState == TX_DATA && txBitEnd)
        txBit <= txBit + 1'b1;
    end
  end

  always_comb begin
    txStrb.load  = txLoad;
    txStrb.shift = (txState == TX_DATA) && txBitEnd;
    unique case (txState)
      TX_START: txStrb.sel = SEL_START;
      TX_DATA:  txStrb.sel = SEL_DATA;
      TX_PAR:   txStrb.sel = SEL_PAR;
      default:  txStrb.sel = SEL_IDLE;
    endcase
  end

  // ---------------- receive sequencing ----------------
  rxState_e        rxState, rxNext;
  logic [OS_W-1:0] rxOs;
  logic [2:0]      rxBit;
  logic            rxSample;

  assign rxSample = osTick &&
                    ((rxState == RX_START) ? (rxOs == osHalf) : (rxOs == osLast));

  always_comb begin
    rxNext = rxState;
    rxStrb = '0;
    unique case (rxState)
      RX_IDLE:
        if (osTick && !rxLine) begin
          rxNext       = RX_START;
          rxStrb.clear = 1'b1;
        end
      RX_START:
        if (rxSample) rxNext = rxLine ? RX_IDLE : RX_DATA;
      RX_DATA:
        if (rxSample) begin
          rxStrb.takeData = 1'b1;
          if (rxBit == lastBit) rxNext = parityEn ? RX_PAR : RX_STOP1;
        end
      RX_PAR:
        if (rxSample) begin
          rxStrb.takePar = 1'b1;
          rxNext         = RX_STOP1;
        end
      RX_STOP1:
        if (rxSample) begin
          rxStrb.takeStop1 = 1'b1;
          if (twoStop) rxNext = RX_STOP2;
          else begin
            rxStrb.capture = 1'b1;
            rxNext         = rxLine ? RX_IDLE : RX_HOLD;
          end
        end
      RX_STOP2:
        if (rxSample) begin
          rxStrb.capture = 1'b1;
          rxNext         = rxLine ? RX_IDLE : RX_HOLD;
        end
      RX_HOLD:
        if (rxLine) rxNext = RX_IDLE;
      default: rxNext = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxOs    <= '0;
      rxBit   <= '0;
    end else begin
      rxState <= rxNext;
      if (rxState == RX_IDLE)
        rxOs <= '0;
      else if (osTick)
        rxOs <= rxSample ? '0 : rxOs + 1'b1;
      if (rxStrb.clear)
        rxBit <= '0;
      else if (rxStrb.takeData)
        rxBit <= rxBit + 1'b1;
    end
  end

endmodule

// File: rtl/uart_frame_datapath.sv
module uart_frame_datapath
  import uart_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] wordLen,
  input  logic       parityOdd,
  input  logic       parityStick,
  input  logic       sendBreak,
  input  logic [7:0] txData,
  input  txStrb_t    txStrb,
  output logic       txOut,
  input  logic       rxIn,
  input  rxStrb_t    rxStrb,
  input  logic       rxReady,
  output logic       rxLine,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       rxFrameErr,
  output logic       rxParityErr,
  output logic       rxBreak,
  output logic       rxOverrun
);

  logic [7:0] wordMask, txMasked;
  assign wordMask = 8'hFF >> (2'd3 - wordLen);
  assign txMasked = txData & wordMask;

  // ---------------- transmit path ----------------
  logic [7:0] txShift;
  logic       txParBit, lineBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      txParBit <= 1'b0;
    end else if (txStrb.load) begin
      txShift  <= txMasked;
      txParBit <= parityStick ? parityOdd : ((^txMasked) ^ parityOdd);
    end else if (txStrb.shift) begin
      txShift  <= txShift >> 1;
    end
  end

  always_comb begin
    unique case (txStrb.sel)
      SEL_START: lineBit = 1'b0;
      SEL_DATA:  lineBit = txShift[0];
      SEL_PAR:   lineBit = txParBit;
      default:   lineBit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txOut <= 1'b1;
    else       txOut <= sendBreak ? 1'b0 : lineBit;
  end

  // ---------------- receive path ----------------
  logic       rxMeta;
  logic [7:0] rxShift;
  logic       rxParAcc, parBad, stop1Low, allLow;
  logic       brkNow, ferrNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxLine <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxLine <= rxMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      rxParAcc <= 1'b0;
      parBad   <= 1'b0;
      stop1Low <= 1'b0;
      allLow   <= 1'b1;
    end else if (rxStrb.clear) begin
      rxShift  <= '0;
      rxParAcc <= 1'b0;
      parBad   <= 1'b0;
      stop1Low <= 1'b0;
      allLow   <= 1'b1;
    end else begin
      if (rxStrb.takeData) begin
        rxShift  <= {rxLine, rxShift[7:1]};
        rxParAcc <= rxParAcc ^ rxLine;
      end
      if (rxStrb.takePar)
        parBad <= rxLine != (parityStick ? parityOdd : (rxParAcc ^ parityOdd));
      if (rxStrb.takeStop1)
        stop1Low <= !rxLine;
      if (rxStrb.takeData || rxStrb.takePar || rxStrb.takeStop1)
        allLow <= allLow && !rxLine;
    end
  end

  assign brkNow  = allLow && !rxLine;
  assign ferrNow = rxStrb.takeStop1 ? !rxLine : stop1Low;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData      <= '0;
      rxValid     <= 1'b0;
      rxFrameErr  <= 1'b0;
      rxParityErr <= 1'b0;
      rxBreak     <= 1'b0;
      rxOverrun   <= 1'b0;
    end else if (rxStrb.capture) begin
      rxData      <= brkNow ? 8'h00 : (rxShift >> (2'd3 - wordLen));
      rxValid     <= 1'b1;
      rxFrameErr  <= ferrNow;
      rxParityErr <= parBad && !brkNow;
      rxBreak     <= brkNow;
      rxOverrun   <= rxValid && !rxReady;
    end else if (rxValid && rxReady) begin
      rxValid     <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_frame_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int OS_NORMAL = 16,
  parameter int OS_FAST   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             fastMode,
  input  logic [1:0]       wordLen,
  input  logic             parityEn,
  input  logic             parityOdd,
  input  logic             parityStick,
  input  logic             twoStop,
  input  logic             sendBreak,
  input  logic [7:0]       txData,
  input  logic             txValid,
  output logic             txReady,
  output logic             txOut,
  input  logic             rxIn,
  output logic [7:0]       rxData,
  output logic             rxValid,
  input  logic             rxReady,
  output logic             rxFrameErr,
  output logic             rxParityErr,
  output logic             rxBreak,
  output logic             rxOverrun
);

  logic    osTick, rxLine;
  txStrb_t txStrb;
  rxStrb_t rxStrb;

  uart_baud_tick #(.DIV_W(DIV_W)) i_tick (
    .clk    (clk),
    .rstN   (rstN),
    .baudDiv(baudDiv),
    .osTick (osTick)
  );

  uart_frame_ctrl #(.OS_NORMAL(OS_NORMAL), .OS_FAST(OS_FAST)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .osTick   (osTick),
    .fastMode (fastMode),
    .wordLen  (wordLen),
    .parityEn (parityEn),
    .twoStop  (twoStop),
    .sendBreak(sendBreak),
    .txValid  (txValid),
    .txReady  (txReady),
    .txStrb   (txStrb),
    .rxLine   (rxLine),
    .rxStrb   (rxStrb)
  );

  uart_frame_datapath i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wordLen    (wordLen),
    .parityOdd  (parityOdd),
    .parityStick(parityStick),
    .sendBreak  (sendBreak),
    .txData     (txData),
    .txStrb     (txStrb),
    .txOut      (txOut),
    .rxIn       (rxIn),
    .rxStrb     (rxStrb),
    .rxReady    (rxReady),
    .rxLine     (rxLine),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .rxFrameErr (rxFrameErr),
    .rxParityErr(rxParityErr),
    .rxBreak    (rxBreak),
    .rxOverrun  (rxOverrun)
  );

endmodule

// File: rtl/uart_frame_engine_chk.sv
module uart_frame_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sendBreak,
  input logic       txValid,
  input logic       txReady,
  input logic       txOut,
  input logic       rxValid,
  input logic       rxReady,
  input logic       rxFrameErr,
  input logic       rxParityErr,
  input logic       rxBreak,
  input logic [7:0] rxData
);

  // R5
  break_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    sendBreak |=> !txOut);

  // R4
  ready_break_chk: assert property (@(posedge clk) disable iff (!rstN)
    sendBreak |-> !txReady);

  // R4
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && $past(txReady)) |-> txOut);

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> rxValid);

  // R10
  brk_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxBreak) |-> (rxFrameErr && !rxParityErr && rxData == 8'h00));

endmodule

bind uart_frame_engine uart_frame_engine_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sendBreak  (sendBreak),
  .txValid    (txValid),
  .txReady    (txReady),
  .txOut      (txOut),
  .rxValid    (rxValid),
  .rxReady    (rxReady),
  .rxFrameErr (rxFrameErr),
  .rxParityErr(rxParityErr),
  .rxBreak    (rxBreak),
  .rxData     (rxData)
);

// File: tb/test_uart_frame_engine.sv
module test_uart_frame_engine;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] baudDiv = 16'(DIV);
  logic        fastMode = 1'b0;
  logic [1:0]  wordLen = 2'd3;
  logic        parityEn = 1'b0, parityOdd = 1'b0, parityStick = 1'b0, twoStop = 1'b0;
  logic        sendBreak = 1'b0;
  logic [7:0]  txData = '0;
  logic        txValid = 1'b0;
  logic        txReady, txOut;
  logic        rxIn;
  logic [7:0]  rxData;
  logic        rxValid, rxReady = 1'b1;
  logic        rxFrameErr, rxParityErr, rxBreak, rxOverrun;
  logic        loopBack = 1'b0, benchRx = 1'b1;

  assign rxIn = loopBack ? txOut : benchRx;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_engine i_uart_frame_engine (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .fastMode(fastMode), .wordLen(wordLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .parityStick(parityStick), .twoStop(twoStop),
    .sendBreak(sendBreak), .txData(txData), .txValid(txValid), .txReady(txReady), .txOut(txOut),
    .rxIn(rxIn), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr), .rxBreak(rxBreak), .rxOverrun(rxOverrun)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bitClk();
    return (fastMode ? 8 : 16) * (DIV + 1);
  endfunction

  function automatic logic [7:0] maskOf();
    return 8'hFF >> (3 - wordLen);
  endfunction

  function automatic logic expPar(input logic [7:0] d);
    return parityStick ? parityOdd : ((^(d & maskOf())) ^ parityOdd);
  endfunction

  // bit 0 is the start bit; bits beyond the frame stay high
  function automatic logic [15:0] frameBits(input logic [7:0] d, output int len);
    logic [15:0] b;
    int k;
    b    = '1;
    b[0] = 1'b0;
    k    = 1;
    for (int i = 0; i < int'(wordLen) + 5; i++) begin b[k] = d[i]; k++; end
    if (parityEn) begin b[k] = expPar(d); k++; end
    k   = k + (twoStop ? 2 : 1);
    len = k;
    return b;
  endfunction

  task automatic sendTx(input logic [7:0] d);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData  = d;
    txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    check(txReady == 1'b0, "R4 ready drops after accept", int'(txReady), 0);
  endtask

  task automatic decodeTx(output logic [15:0] got, input int len);
    got = '1;
    @(negedge clk);
    while (txOut) @(negedge clk);
    repeat (bitClk() / 2) @(negedge clk);
    got[0] = txOut;
    for (int i = 1; i < len; i++) begin
      repeat (bitClk()) @(negedge clk);
      got[i] = txOut;
    end
  endtask

  task automatic driveRx(input logic [15:0] bits, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      benchRx = bits[i];
      repeat (bitClk() - 1) @(negedge clk);
    end
    @(negedge clk);
    benchRx = 1'b1;
  endtask

  task automatic waitRx(output logic [7:0] d, output logic [3:0] f, output bit seen);
    seen = 0; d = '0; f = '0;
    for (int c = 0; c < 20 * bitClk(); c++) begin
      @(negedge clk);
      if (rxValid) begin
        d = rxData; f = {rxBreak, rxFrameErr, rxParityErr, rxOverrun}; seen = 1;
        break;
      end
    end
  endtask

  logic [15:0] expBits, gotBits;
  logic [7:0]  rd, d;
  logic [3:0]  rf;
  bit          seen;
  int          len, cnt, nValid;

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R12 during reset
    check(txOut == 1'b1, "R12 txOut in reset", int'(txOut), 1);
    check(rxValid == 1'b0, "R12 rxValid in reset", int'(rxValid), 0);
    check(txReady == 1'b1, "R12 txReady in reset", int'(txReady), 1);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(txOut == 1'b1 && rxValid == 1'b0, "R12 idle after reset", int'({txOut, rxValid}), 2);

    // R1 bit period: 8N1 zero byte gives nine low bits
    for (int m = 0; m < 2; m++) begin
      fastMode = m[0]; wordLen = 2'd3; parityEn = 0; twoStop = 0;
      fork
        sendTx(8'h00);
        begin
          @(negedge clk);
          while (txOut) @(negedge clk);
          cnt = 0;
          while (!txOut) begin cnt++; @(negedge clk); end
        end
      join
      check(cnt <= 9 * bitClk() && cnt > 9 * bitClk() - (DIV + 1),
            "R1 low run of nine bits", cnt, 9 * bitClk());
      repeat (2 * bitClk()) @(negedge clk);
    end

    // R2 R3 R7 random loopback traffic
    loopBack = 1'b1;
    for (int it = 0; it < 30; it++) begin
      int pm;
      fastMode = 1'($urandom);
      wordLen  = 2'($urandom);
      twoStop  = 1'($urandom);
      pm       = int'($urandom % 4);
      parityEn = (pm != 0);
      parityOdd = (pm == 2) || (pm == 3 && 1'($urandom));
      parityStick = (pm == 3);
      d = 8'($urandom);
      expBits = frameBits(d, len);
      fork
        sendTx(d);
        decodeTx(gotBits, len);
        waitRx(rd, rf, seen);
      join
      check(gotBits == expBits, "R2 R3 transmitted frame", int'(gotBits), int'(expBits));
      check(seen && rd == (d & maskOf()), "R7 loopback byte right-aligned", int'(rd), int'(d & maskOf()));
      check(rf == 4'b0000, "R8 R9 no error flags on clean frame", int'(rf), 0);
      repeat (bitClk()) @(negedge clk);
    end
    loopBack = 1'b0;
    fastMode = 0; wordLen = 2'd3; parityEn = 0; parityOdd = 0; parityStick = 0; twoStop = 0;
    repeat (2 * bitClk()) @(negedge clk);

    // R5 break generation
    @(negedge clk);
    sendBreak = 1'b1;
    txValid   = 1'b1;
    txData    = 8'hFF;
    @(negedge clk);
    check(txOut == 1'b0, "R5 line low after break request", int'(txOut), 0);
    repeat (3 * bitClk()) @(negedge clk);
    check(txOut == 1'b0 && txReady == 1'b0, "R5 still low, no accept", int'({txOut, txReady}), 0);
    txValid = 1'b0;
    @(negedge clk);
    sendBreak = 1'b0;
    repeat (2) @(negedge clk);
    check(txOut == 1'b1 && txReady == 1'b1, "R5 line idle after release", int'({txOut, txReady}), 3);

    // R6 short low pulse
    nValid = 0;
    fork
      begin benchRx = 1'b0; repeat (3 * (DIV + 1)) @(negedge clk); benchRx = 1'b1; end
      for (int c = 0; c < 24 * bitClk(); c++) begin @(negedge clk); if (rxValid) nValid++; end
    join
    check(nValid == 0, "R6 glitch rejected", nValid, 0);

    // R8 parity error, 8E1
    parityEn = 1; parityOdd = 0;
    expBits = frameBits(8'hA5, len);
    expBits[9] = ~expBits[9];
    fork driveRx(expBits, len); waitRx(rd, rf, seen); join
    check(seen && rf == 4'b0010, "R8 parity error flag", int'(rf), 2);
    check(rd == 8'hA5, "R8 data with parity error", int'(rd), 8'hA5);
    repeat (bitClk()) @(negedge clk);

    // R9 framing error, 7N1
    parityEn = 0; wordLen = 2'd2;
    expBits = frameBits(8'h5B, len);
    expBits[len-1] = 1'b0;
    fork driveRx(expBits, len); waitRx(rd, rf, seen); join
    check(seen && rf == 4'b0100, "R9 framing error flag", int'(rf), 4);
    check(rd == 8'h5B, "R9 data with framing error", int'(rd), 8'h5B);
    repeat (bitClk()) @(negedge clk);

    // R10 break detection, 8O1
    wordLen = 2'd3; parityEn = 1; parityOdd = 1;
    nValid = 0; rf = '1; rd = '1;
    fork
      begin benchRx = 1'b0; repeat (24 * bitClk()) @(negedge clk); benchRx = 1'b1; end
      for (int c = 0; c < 28 * bitClk(); c++) begin
        @(negedge clk);
        if (rxValid) begin
          nValid++;
          if (nValid == 1) begin rd = rxData; rf = {rxBreak, rxFrameErr, rxParityErr, rxOverrun}; end
        end
      end
    join
    check(nValid == 1, "R10 one report per long low", nValid, 1);
    check(rf == 4'b1100 && rd == 8'h00, "R10 break flags and data", int'({rf, rd}), 12'hC00);
    expBits = frameBits(8'h3C, len);
    fork driveRx(expBits, len); waitRx(rd, rf, seen); join
    check(seen && rd == 8'h3C && rf == 4'b0000, "R10 clean byte after break", int'({rf, rd}), 8'h3C);
    repeat (bitClk()) @(negedge clk);

    // R11 overrun, R7 hold, 8N1
    parityEn = 0; parityOdd = 0;
    rxReady = 1'b0;
    expBits = frameBits(8'h11, len);
    driveRx(expBits, len);
    repeat (bitClk()) @(negedge clk);
    check(rxValid && rxData == 8'h11 && !rxOverrun, "R7 byte held while not ready",
          int'({rxValid, rxOverrun, rxData}), 12'h211);
    expBits = frameBits(8'hE7, len);
    driveRx(expBits, len);
    check(rxValid && rxData == 8'hE7 && rxOverrun, "R11 overrun with new byte",
          int'({rxValid, rxOverrun, rxData}), 12'h3E7);
    @(negedge clk);
    rxReady = 1'b1;
    @(negedge clk);
    check(rxValid == 1'b0, "R7 valid clears on accept", int'(rxValid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule